// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block converts a segment value and an offset into a linear address. A single mode input selects how the conversion is done for each request. When the mode input is low, the block runs the unprotected path. That path shifts the segment value left by four bits, adds the offset and keeps the low 20 bits. When the mode input is high, the low bits of the segment value select one entry of a small descriptor table held inside the block. The entry supplies a base and a limit. The offset is checked against the limit, and the base is added only when the check passes.

The block also holds the current privilege level, which is either 0 (kernel) or 3 (user). Only kernel code may fill the descriptor table or change the level. An attempt at user level has no effect and raises a one-cycle protection fault pulse. Each translation result is registered and appears one cycle after its request, together with a fault code.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid and prot_fault are 0, cur_priv is 0 and every descriptor entry is invalid. A protected-mode request then returns fault code 2.
- R2: rsp_valid is 1 in the cycle after each cycle in which req_valid is 1, and 0 after each cycle in which it is 0.
- R3: With prot_en low, rsp_addr = (req_seg × 16 + req_off) mod 2^20, the upper address bits are 0 and rsp_code is 0 (no fault).
- R4: With prot_en high, req_seg bits [2:0] pick the entry and the upper selector bits are ignored. A passing access gives rsp_addr = (base + req_off) mod 2^32 with rsp_code 0.
- R5: With prot_en high and a valid entry, an offset not below the zero-extended 20-bit limit gives rsp_code 1 and rsp_addr 0.
- R6: Selecting an invalid entry gives rsp_code 2 and rsp_addr 0, whatever the offset. This check ranks above the limit check, and rsp_code 3 is never produced.
- R7: A table write at level 0 stores base, limit and valid flag into the indexed entry. A request made in the same cycle still sees the old entry, and later requests see the new one.
- R8: A table write at level 3 leaves the table unchanged. prot_fault is 1 in the following cycle and returns to 0 after that when no further denied write occurs.
- R9: A privilege write at level 0 sets cur_priv to 3 when priv_wr_user is 1 and to 0 otherwise, taking effect in the next cycle. At level 3 it is ignored and pulses prot_fault. cur_priv is only ever 0 or 3.
- R10: The mode is taken per request from prot_en. The same segment and offset translate differently in back-to-back requests of opposite mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_en | input | 1 | Mode select for the request: 1 = descriptor lookup, 0 = shift-and-add |
| priv_wr_en | input | 1 | Request to change the privilege level |
| priv_wr_user | input | 1 | New level: 1 = user (3), 0 = kernel (0) |
| tbl_wr_en | input | 1 | Descriptor table write strobe |
| tbl_wr_idx | input | 3 | Entry to write |
| tbl_wr_base | input | 32 | Base for the written entry |
| tbl_wr_limit | input | 20 | Limit for the written entry |
| tbl_wr_valid | input | 1 | Valid flag for the written entry |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 16 | Segment value or selector |
| req_off | input | 32 | Offset |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_addr | output | 32 | Translated address, 0 on fault |
| rsp_code | output | 2 | 0 = ok, 1 = limit fault, 2 = invalid entry |
| prot_fault | output | 1 | Pulse after a denied write at user level |
| cur_priv | output | 2 | Current privilege level (0 or 3) |

## Verification
The vector table drives the unprotected path with a zero segment and offset, with sums that carry past bit 19 and are truncated, and with a sum that lands exactly on the top 20-bit address. These separate a correct shift-and-add from one that does not wrap or that shifts by the wrong amount. The protected path is tried at offsets one below and exactly at the limit, which exposes an off-by-one in the comparison. A base that wraps past 2^32 and a zero limit are also included. Invalid entries are tried with both small and maximal offsets, which shows that the invalid-entry check ranks above the limit check. Selectors with upper bits set show that those bits are ignored. Directed steps then cover a write and a request in the same cycle, the user-level denials and their fault pulses, and the state after a second reset.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   // Result code of a translation.
   typedef enum logic [1:0] {
      XL_OK     = 2'd0,
      XL_LIMIT  = 2'd1,
      XL_ABSENT = 2'd2
   } xl_code_e;

   localparam logic [1:0] PRIV_KERNEL = 2'd0;
   localparam logic [1:0] PRIV_USER   = 2'd3;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
   parameter int IDX_W  = 3,
   parameter int BASE_W = 32,
   parameter int LIM_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [LIM_W-1:0]  wr_limit,
   input  logic              wr_valid,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [LIM_W-1:0]  rd_limit,
   output logic              rd_valid
);
   localparam int ENTRIES = 1 << IDX_W;

   logic [BASE_W-1:0] base_q  [ENTRIES];
   logic [LIM_W-1:0]  limit_q [ENTRIES];
   logic [ENTRIES-1:0] valid_q;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(e));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[e]  <= '0;
            limit_q[e] <= '0;
            valid_q[e] <= 1'b0;
         end else if (hit) begin
            base_q[e]  <= wr_base;
            limit_q[e] <= wr_limit;
            valid_q[e] <= wr_valid;
         end
      end
   end

   assign rd_base  = base_q[rd_idx];
   assign rd_limit = limit_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/seg_priv_ctrl.sv
module seg_priv_ctrl
   import seg_xlate_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       priv_wr_en,
   input  logic       priv_wr_user,
   input  logic       tbl_wr_en,
   output logic       kernel,
   output logic [1:0] cur_priv,
   output logic       prot_fault
);
   logic [1:0] priv_q;
   logic       fault_q;

   assign kernel = (priv_q == PRIV_KERNEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         priv_q  <= PRIV_KERNEL;
         fault_q <= 1'b0;
      end else begin
         if (priv_wr_en && kernel)
            priv_q <= priv_wr_user ? PRIV_USER : PRIV_KERNEL;
         fault_q <= !kernel && (priv_wr_en || tbl_wr_en);
      end
   end

   assign cur_priv   = priv_q;
   assign prot_fault = fault_q;

endmodule

// File: rtl/seg_addr_path.sv
module seg_addr_path
   import seg_xlate_pkg::*;
#(
   parameter int  SEG_W     = 16,
   parameter int  ADDR_W    = 32,
   parameter int  LIM_W     = 20,
   parameter int  SHIFT     = 4,
   parameter int  REAL_W    = 20,
   parameter bit  REAL_WRAP = 1'b1
) (
   input  logic              prot_en,
   input  logic [SEG_W-1:0]  seg,
   input  logic [ADDR_W-1:0] off,
   input  logic [ADDR_W-1:0] base,
   input  logic [LIM_W-1:0]  limit,
   input  logic              entry_ok,
   output logic [ADDR_W-1:0] addr,
   output xl_code_e          code
);
   localparam logic [ADDR_W-1:0] REAL_MASK = (ADDR_W'(1) << REAL_W) - ADDR_W'(1);

   logic [ADDR_W-1:0] real_sum, real_addr, prot_sum, lim_ext;

   assign real_sum = (ADDR_W'(seg) << SHIFT) + off;
   assign prot_sum = base + off;
   assign lim_ext  = {{(ADDR_W-LIM_W){1'b0}}, limit};

   if (REAL_WRAP) begin : g_wrap
      assign real_addr = real_sum & REAL_MASK;
   end else begin : g_full
      assign real_addr = real_sum;
   end

   always_comb begin
      addr = '0;
      code = XL_OK;
      if (!prot_en) begin
         addr = real_addr;
      end else if (!entry_ok) begin
         code = XL_ABSENT;
      end else if (off >= lim_ext) begin
         code = XL_LIMIT;
      end else begin
         addr = prot_sum;
      end
   end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int IDX_W     = 3,
   parameter int SEG_W     = 16,
   parameter int ADDR_W    = 32,
   parameter int LIM_W     = 20,
   parameter int SHIFT     = 4,
   parameter int REAL_W    = 20,
   parameter bit REAL_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_en,
   input  logic              priv_wr_en,
   input  logic              priv_wr_user,
   input  logic              tbl_wr_en,
   input  logic [IDX_W-1:0]  tbl_wr_idx,
   input  logic [ADDR_W-1:0] tbl_wr_base,
   input  logic [LIM_W-1:0]  tbl_wr_limit,
   input  logic              tbl_wr_valid,
   input  logic              req_valid,
   input  logic [SEG_W-1:0]  req_seg,
   input  logic [ADDR_W-1:0] req_off,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [1:0]        rsp_code,
   output logic              prot_fault,
   output logic [1:0]        cur_priv
);
   if (IDX_W < 1 || IDX_W > SEG_W) begin : g_bad_idx
      $error("seg_xlate: IDX_W must lie in 1..SEG_W");
   end
   if (SEG_W + SHIFT > ADDR_W) begin : g_bad_seg
      $error("seg_xlate: shifted segment exceeds address width");
   end
   if (LIM_W >= ADDR_W) begin : g_bad_lim
      $error("seg_xlate: limit must be narrower than address");
   end
   if (REAL_W > ADDR_W) begin : g_bad_real
      $error("seg_xlate: unprotected width exceeds address width");
   end

   logic              kernel;
   logic [ADDR_W-1:0] ent_base;
   logic [LIM_W-1:0]  ent_limit;
   logic              ent_valid;
   logic [ADDR_W-1:0] path_addr;
   xl_code_e          path_code;

   seg_priv_ctrl u_priv (
      .clk          (clk),
      .rst_n        (rst_n),
      .priv_wr_en   (priv_wr_en),
      .priv_wr_user (priv_wr_user),
      .tbl_wr_en    (tbl_wr_en),
      .kernel       (kernel),
      .cur_priv     (cur_priv),
      .prot_fault   (prot_fault)
   );

   seg_desc_table #(
      .IDX_W  (IDX_W),
      .BASE_W (ADDR_W),
      .LIM_W  (LIM_W)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (tbl_wr_en && kernel),
      .wr_idx   (tbl_wr_idx),
      .wr_base  (tbl_wr_base),
      .wr_limit (tbl_wr_limit),
      .wr_valid (tbl_wr_valid),
      .rd_idx   (req_seg[IDX_W-1:0]),
      .rd_base  (ent_base),
      .rd_limit (ent_limit),
      .rd_valid (ent_valid)
   );

   seg_addr_path #(
      .SEG_W     (SEG_W),
      .ADDR_W    (ADDR_W),
      .LIM_W     (LIM_W),
      .SHIFT     (SHIFT),
      .REAL_W    (REAL_W),
      .REAL_WRAP (REAL_WRAP)
   ) u_path (
      .prot_en  (prot_en),
      .seg      (req_seg),
      .off      (req_off),
      .base     (ent_base),
      .limit    (ent_limit),
      .entry_ok (ent_valid),
      .addr     (path_addr),
      .code     (path_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_code  <= XL_OK;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_addr <= path_addr;
            rsp_code <= path_code;
         end
      end
   end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int ADDR_W = 32,
   parameter int REAL_W = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prot_en,
   input logic              priv_wr_en,
   input logic              tbl_wr_en,
   input logic              req_valid,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [1:0]        rsp_code,
   input logic              prot_fault,
   input logic [1:0]        cur_priv
);
   localparam logic [ADDR_W-1:0] HI_MASK = ~((ADDR_W'(1) << REAL_W) - ADDR_W'(1));

   p_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   p_real_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !prot_en) |=> (rsp_code == 2'd0 && (rsp_addr & HI_MASK) == '0));
   p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != 2'd0) |-> rsp_addr == '0);
   p_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_code != 2'd3);
   p_user_tbl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_wr_en && cur_priv != 2'd0) |=> prot_fault);
   p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!tbl_wr_en && !priv_wr_en) |=> !prot_fault);
   p_priv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cur_priv != 2'd0 |=> $stable(cur_priv));
   p_priv_val_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cur_priv == 2'd0 || cur_priv == 2'd3);

endmodule

bind seg_xlate seg_xlate_chk #(
   .ADDR_W (ADDR_W),
   .REAL_W (REAL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .prot_en    (prot_en),
   .priv_wr_en (priv_wr_en),
   .tbl_wr_en  (tbl_wr_en),
   .req_valid  (req_valid),
   .rsp_valid  (rsp_valid),
   .rsp_addr   (rsp_addr),
   .rsp_code   (rsp_code),
   .prot_fault (prot_fault),
   .cur_priv   (cur_priv)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prot_en = 1'b0;
   logic        priv_wr_en = 1'b0;
   logic        priv_wr_user = 1'b0;
   logic        tbl_wr_en = 1'b0;
   logic [2:0]  tbl_wr_idx = '0;
   logic [31:0] tbl_wr_base = '0;
   logic [19:0] tbl_wr_limit = '0;
   logic        tbl_wr_valid = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_seg = '0;
   logic [31:0] req_off = '0;
   logic        rsp_valid;
   logic [31:0] rsp_addr;
   logic [1:0]  rsp_code;
   logic        prot_fault;
   logic [1:0]  cur_priv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   seg_xlate i_seg_xlate (
      .clk(clk), .rst_n(rst_n), .prot_en(prot_en),
      .priv_wr_en(priv_wr_en), .priv_wr_user(priv_wr_user),
      .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_base(tbl_wr_base),
      .tbl_wr_limit(tbl_wr_limit), .tbl_wr_valid(tbl_wr_valid),
      .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_code(rsp_code),
      .prot_fault(prot_fault), .cur_priv(cur_priv)
   );

   // {prot, seg, off, expected addr, expected code}
   localparam int NV = 17;
   localparam logic [82:0] VEC [NV] = '{
      {1'b0, 16'h0000, 32'h0000_0000, 32'h0000_0000, 2'd0},  // R3 zero
      {1'b0, 16'h1234, 32'h0000_0010, 32'h0001_2350, 2'd0},  // R3
      {1'b0, 16'hFFFF, 32'h0000_0010, 32'h0000_0000, 2'd0},  // R3 wrap
      {1'b0, 16'hF000, 32'h0000_FFFF, 32'h000F_FFFF, 2'd0},  // R3 top
      {1'b1, 16'h0000, 32'h0000_00FF, 32'h0000_10FF, 2'd0},  // R4
      {1'b1, 16'h0000, 32'h0000_0100, 32'h0000_0000, 2'd1},  // R5 at limit
      {1'b1, 16'h0001, 32'h000F_FFFE, 32'h800F_FFFE, 2'd0},  // R4
      {1'b1, 16'h0001, 32'h000F_FFFF, 32'h0000_0000, 2'd1},  // R5
      {1'b1, 16'h0002, 32'h0000_1FFF, 32'h0000_0FFF, 2'd0},  // R4 base wrap
      {1'b1, 16'h0003, 32'h0000_0000, 32'h0000_0000, 2'd1},  // R5 zero limit
      {1'b1, 16'h0006, 32'h0000_0000, 32'h0000_0000, 2'd2},  // R6 written invalid
      {1'b1, 16'h0007, 32'h0000_0005, 32'h0000_0000, 2'd2},  // R6 never written
      {1'b1, 16'hFFF9, 32'h0000_0010, 32'h8000_0010, 2'd0},  // R4 upper bits
      {1'b1, 16'h0001, 32'h1000_0000, 32'h0000_0000, 2'd1},  // R5 wide offset
      {1'b1, 16'h0006, 32'hFFFF_FFFF, 32'h0000_0000, 2'd2},  // R6 priority
      {1'b0, 16'h0001, 32'h0000_0010, 32'h0000_0020, 2'd0},  // R10 real
      {1'b1, 16'h0001, 32'h0000_0010, 32'h8000_0010, 2'd0}   // R10 protected
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tbl_write(input logic [2:0] idx, input logic [31:0] b,
                            input logic [19:0] l, input logic v);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_base = b;
      tbl_wr_limit = l; tbl_wr_valid = v;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   // Drives one request for one cycle; result sampled at the following negedge.
   task automatic xlate(input logic p, input logic [15:0] s, input logic [31:0] o,
                        input logic [31:0] ea, input logic [1:0] ec, input string req);
      @(negedge clk);
      req_valid = 1'b1; prot_en = p; req_seg = s; req_off = o;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, "R2 valid", 32'(rsp_valid), 32'd1);
      chk(rsp_addr == ea, req, rsp_addr, ea);
      chk(rsp_code == ec, req, 32'(rsp_code), 32'(ec));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
      chk(prot_fault == 1'b0, "R1 prot_fault", 32'(prot_fault), 32'd0);
      chk(cur_priv == 2'd0, "R1 cur_priv", 32'(cur_priv), 32'd0);
      rst_n = 1'b1;
      xlate(1'b1, 16'h0002, 32'h0, 32'h0, 2'd2, "R1 table empty");

      // R7 kernel fills the table
      tbl_write(3'd0, 32'h0000_1000, 20'h00100, 1'b1);
      tbl_write(3'd1, 32'h8000_0000, 20'hFFFFF, 1'b1);
      tbl_write(3'd2, 32'hFFFF_F000, 20'h02000, 1'b1);
      tbl_write(3'd3, 32'h0000_0000, 20'h00000, 1'b1);
      tbl_write(3'd6, 32'h0000_1234, 20'hFFFFF, 1'b0);

      for (int i = 0; i < NV; i++) begin
         logic [82:0] v;
         v = VEC[i];
         xlate(v[82], v[81:66], v[65:34], v[33:2], v[1:0], "R3-R6/R10 vector");
      end

      // R2 idle cycle gives no result
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2 idle", 32'(rsp_valid), 32'd0);

      // R7 same-cycle write and request sees old entry
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = 3'd4; tbl_wr_base = 32'h0000_4000;
      tbl_wr_limit = 20'h00010; tbl_wr_valid = 1'b1;
      req_valid = 1'b1; prot_en = 1'b1; req_seg = 16'h0004; req_off = 32'h0;
      @(negedge clk);
      tbl_wr_en = 1'b0; req_valid = 1'b0;
      chk(rsp_code == 2'd2, "R7 old entry", 32'(rsp_code), 32'd2);
      xlate(1'b1, 16'h0004, 32'h0000_0008, 32'h0000_4008, 2'd0, "R7 new entry");

      // R9 kernel drops to user
      @(negedge clk);
      priv_wr_en = 1'b1; priv_wr_user = 1'b1;
      @(negedge clk);
      priv_wr_en = 1'b0;
      chk(cur_priv == 2'd3, "R9 to user", 32'(cur_priv), 32'd3);
      chk(prot_fault == 1'b0, "R9 kernel write no fault", 32'(prot_fault), 32'd0);

      // R8 user table write ignored, fault pulse
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_idx = 3'd5; tbl_wr_base = 32'h0000_5000;
      tbl_wr_limit = 20'h000FF; tbl_wr_valid = 1'b1;
      @(negedge clk);
      tbl_wr_en = 1'b0;
      chk(prot_fault == 1'b1, "R8 pulse", 32'(prot_fault), 32'd1);
      @(negedge clk);
      chk(prot_fault == 1'b0, "R8 pulse end", 32'(prot_fault), 32'd0);
      xlate(1'b1, 16'h0005, 32'h0, 32'h0, 2'd2, "R8 entry unchanged");

      // R9 user cannot raise privilege
      @(negedge clk);
      priv_wr_en = 1'b1; priv_wr_user = 1'b0;
      @(negedge clk);
      priv_wr_en = 1'b0;
      chk(cur_priv == 2'd3, "R9 user stays", 32'(cur_priv), 32'd3);
      chk(prot_fault == 1'b1, "R9 pulse", 32'(prot_fault), 32'd1);

      // R1 second reset clears level and table
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(cur_priv == 2'd0, "R1 priv after reset", 32'(cur_priv), 32'd0);
      chk(prot_fault == 1'b0, "R1 fault after reset", 32'(prot_fault), 32'd0);
      rst_n = 1'b1;
      xlate(1'b1, 16'h0001, 32'h0, 32'h0, 2'd2, "R1 table cleared");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule